// File: doc/BRIEF.md
# Secure Zone Access Guard

The guard sits between a serial command decoder and a nonvolatile user array that is split into zones. For every read or write of one byte it decides whether the access may proceed. For a granted write it also works out the byte value that may actually be committed. It keeps a single password session, a flag for authentication, and a counter of wrong password attempts that saturates. Password comparison and the cryptographic authentication exchange happen outside the block. They arrive as pulses that carry a result.

Each zone has a static mode word and a password set index. The mode word chooses between free access and password protection, and can also require authentication. It can also make the zone read-only, allow only clearing of bits, or apply page write-locking. Under page write-locking, the first byte of each 8-byte page is a lock byte. Each of its bits protects one byte of that page. The stored lock byte of the addressed page and the stored byte at the address are both supplied with the request. The verdict and the committed data appear one cycle after the request.

Top module: `zone_access_guard`

## Requirements
- R1: After reset there is no active password, authentication is cleared, the attempt counter reads 0, `locked_out` is 0 and `resp_valid` is 0.
- R2: A read of a zone whose mode bit 4 (password required) is clear is always granted. If the bit is set, the read is granted only while a password of that zone's set is active. Either a read password or a write password of that set grants the read.
- R3: A write to a password-protected zone needs an active write password of the zone's own set. A read password of that set does not grant the write.
- R4: Only one password is active at a time. A correct presentation replaces the current one. A wrong presentation drops the current one.
- R5: Each wrong presentation increments the attempt counter, which saturates at 4. A correct presentation resets it to 0. While it reads 4, `locked_out` is 1 and presentations change neither the session nor the counter.
- R6: A zone with mode bit 3 set also needs authentication. `auth_ok` sets the authentication flag, and `auth_fail` or reset clears it.
- R7: Every write to a zone with mode bit 0 (modify-forbidden) is denied. Reads of that zone follow R2.
- R8: A granted write to a zone with mode bit 1 (program-only) commits old AND new.
- R9: With mode bit 2 (write-lock), page offset i = addr[2:0]. Byte i with i > 0 may be written only if bit i of the page's lock byte is 1. The lock byte itself (i = 0) may be written only if its bit 0 is 1, and it commits old AND new.
- R10: With write-lock, a write whose `req_first` is 0 (a later byte of a multi-byte write) is denied.
- R11: A request at one rising edge gives `resp_valid` at the next edge. Exactly one of `resp_grant` and `resp_deny` is set then. A granted read returns the stored byte, a granted write returns the committed byte, and a denial returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pw_valid | input | 1 | Password presentation event |
| pw_set | input | 3 | Password set presented |
| pw_write | input | 1 | 1 = write password, 0 = read password |
| pw_ok | input | 1 | Result of the external comparison |
| auth_ok | input | 1 | Pulse: authentication succeeded |
| auth_fail | input | 1 | Pulse: authentication failed |
| zone_mode | input | 80 | Five mode bits per zone, zone z at [5z+4:5z] |
| zone_set | input | 48 | Password set per zone, zone z at [3z+2:3z] |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_first | input | 1 | First byte of a write burst |
| req_zone | input | 4 | Zone number |
| req_addr | input | 9 | Byte address within the zone |
| req_lock | input | 8 | Stored lock byte of the addressed page |
| req_old | input | 8 | Stored byte at the address |
| req_wdata | input | 8 | Byte to write |
| resp_valid | output | 1 | Verdict valid |
| resp_grant | output | 1 | Access granted |
| resp_deny | output | 1 | Access denied |
| resp_data | output | 8 | Read byte, committed byte, or 0 |
| tries | output | 3 | Wrong-attempt counter |
| locked_out | output | 1 | Counter at its limit |

## Verification
The bench uses the default parameters: 16 zones, 8 password sets, a limit of 4 attempts and 8-byte pages. With a limit of 4, saturation and the ignored fifth presentation can be reached in a handful of events. With 8-byte pages, every bit of the lock byte maps to a real page offset. The zones are configured so that each mode bit is exercised alone and in combination (write-lock together with program-only). Two zones are bound to different sets so that a set mismatch can be seen.

// File: rtl/zag_pkg.sv
package zag_pkg;
    localparam int MODE_W = 5;

    // bit 4 pw_en, bit 3 auth_req, bit 2 wlock, bit 1 prog_only, bit 0 no_mod
    typedef struct packed {
        logic pw_en;
        logic auth_req;
        logic wlock;
        logic prog_only;
        logic no_mod;
    } zone_mode_t;
endpackage

// File: rtl/zag_zone_sel.sv
module zag_zone_sel #(
    parameter int NUM_ZONES = 16,
    parameter int SET_W     = 3,
    parameter int ZONE_W    = 4
) (
    input  logic [ZONE_W-1:0]                      zone,
    input  logic [NUM_ZONES*zag_pkg::MODE_W-1:0]   mode_flat,
    input  logic [NUM_ZONES*SET_W-1:0]             set_flat,
    output zag_pkg::zone_mode_t                    mode,
    output logic [SET_W-1:0]                       set
);
    zag_pkg::zone_mode_t modes [NUM_ZONES];
    logic [SET_W-1:0]    sets  [NUM_ZONES];

    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_unpack
        assign modes[z] = mode_flat[z*zag_pkg::MODE_W +: zag_pkg::MODE_W];
        assign sets[z]  = set_flat[z*SET_W +: SET_W];
    end

    assign mode = modes[zone];
    assign set  = sets[zone];
endmodule

// File: rtl/zag_session.sv
module zag_session #(
    parameter int NUM_SETS  = 8,
    parameter int MAX_TRIES = 4,
    parameter int SET_W     = $clog2(NUM_SETS),
    parameter int TRY_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pw_valid,
    input  logic [SET_W-1:0] pw_set,
    input  logic             pw_write,
    input  logic             pw_ok,
    input  logic             auth_ok,
    input  logic             auth_fail,
    output logic             sess_valid,
    output logic             sess_write,
    output logic [SET_W-1:0] sess_set,
    output logic             authed,
    output logic [TRY_W-1:0] tries,
    output logic             locked_out
);
    localparam logic [TRY_W-1:0] TRY_MAX = TRY_W'(MAX_TRIES);

    typedef struct packed {
        logic             valid;
        logic             wr;
        logic [SET_W-1:0] set;
        logic             authed;
        logic [TRY_W-1:0] tries;
    } sess_t;

    sess_t sess_d, sess_q;
    logic  at_limit;

    assign at_limit = (sess_q.tries == TRY_MAX);

    always_comb begin
        sess_d = sess_q;
        if (pw_valid && !at_limit) begin
            if (pw_ok) begin
                sess_d.valid = 1'b1;
                sess_d.wr    = pw_write;
                sess_d.set   = pw_set;
                sess_d.tries = '0;
            end else begin
                sess_d.valid = 1'b0;
                sess_d.tries = sess_q.tries + 1'b1;
            end
        end
        if (auth_ok) begin
            sess_d.authed = 1'b1;
        end else if (auth_fail) begin
            sess_d.authed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sess_q <= '0;
        end else begin
            sess_q <= sess_d;
        end
    end

    assign sess_valid = sess_q.valid;
    assign sess_write = sess_q.wr;
    assign sess_set   = sess_q.set;
    assign authed     = sess_q.authed;
    assign tries      = sess_q.tries;
    assign locked_out = at_limit;

    p_tries_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= TRY_MAX);
    p_ok_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_valid && pw_ok && !locked_out) |=> (tries == '0 && sess_valid));
    p_bad_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_valid && !pw_ok && !locked_out) |=> !sess_valid);
    p_lockout_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_valid && locked_out && !auth_ok && !auth_fail) |=> $stable(sess_q));
endmodule

// File: rtl/zag_write_rules.sv
module zag_write_rules #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 3
) (
    input  zag_pkg::zone_mode_t mode,
    input  logic                is_write,
    input  logic                first,
    input  logic                access_ok,
    input  logic [PAGE_W-1:0]   page_idx,
    input  logic [DATA_W-1:0]   lock_byte,
    input  logic [DATA_W-1:0]   old_byte,
    input  logic [DATA_W-1:0]   new_byte,
    output logic                allow,
    output logic [DATA_W-1:0]   data
);
    logic is_lock_byte;
    logic page_open;

    assign is_lock_byte = (page_idx == '0);
    assign page_open    = lock_byte[page_idx];

    always_comb begin
        allow = 1'b0;
        data  = '0;
        if (!is_write) begin
            allow = access_ok;
            data  = access_ok ? old_byte : '0;
        end else if (access_ok && !mode.no_mod) begin
            if (mode.wlock) begin
                if (first && page_open) begin
                    allow = 1'b1;
                    data  = (is_lock_byte || mode.prog_only) ? (old_byte & new_byte) : new_byte;
                end
            end else begin
                allow = 1'b1;
                data  = mode.prog_only ? (old_byte & new_byte) : new_byte;
            end
        end
    end
endmodule

// File: rtl/zone_access_guard.sv
module zone_access_guard #(
    parameter int NUM_ZONES  = 16,
    parameter int ZONE_BYTES = 512,
    parameter int NUM_SETS   = 8,
    parameter int MAX_TRIES  = 4,
    parameter int PAGE_BYTES = 8,
    parameter int DATA_W     = 8,
    parameter int ZONE_W     = $clog2(NUM_ZONES),
    parameter int ADDR_W     = $clog2(ZONE_BYTES),
    parameter int SET_W      = $clog2(NUM_SETS),
    parameter int TRY_W      = $clog2(MAX_TRIES + 1)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 pw_valid,
    input  logic [SET_W-1:0]                     pw_set,
    input  logic                                 pw_write,
    input  logic                                 pw_ok,
    input  logic                                 auth_ok,
    input  logic                                 auth_fail,
    input  logic [NUM_ZONES*zag_pkg::MODE_W-1:0] zone_mode,
    input  logic [NUM_ZONES*SET_W-1:0]           zone_set,
    input  logic                                 req_valid,
    input  logic                                 req_write,
    input  logic                                 req_first,
    input  logic [ZONE_W-1:0]                    req_zone,
    input  logic [ADDR_W-1:0]                    req_addr,
    input  logic [DATA_W-1:0]                    req_lock,
    input  logic [DATA_W-1:0]                    req_old,
    input  logic [DATA_W-1:0]                    req_wdata,
    output logic                                 resp_valid,
    output logic                                 resp_grant,
    output logic                                 resp_deny,
    output logic [DATA_W-1:0]                    resp_data,
    output logic [TRY_W-1:0]                     tries,
    output logic                                 locked_out
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    typedef struct packed {
        logic              valid;
        logic              grant;
        logic [DATA_W-1:0] data;
    } resp_t;

    zag_pkg::zone_mode_t sel_mode;
    logic [SET_W-1:0]    sel_set;
    logic                sess_valid, sess_write, authed;
    logic [SET_W-1:0]    sess_set;
    logic                set_match, rd_ok, wr_ok, auth_cond, access_ok;
    logic                rule_allow;
    logic [DATA_W-1:0]   rule_data;
    logic                unused_addr_hi;
    resp_t               resp_d, resp_q;

    assign unused_addr_hi = ^req_addr[ADDR_W-1:PAGE_W];

    zag_zone_sel #(
        .NUM_ZONES (NUM_ZONES),
        .SET_W     (SET_W),
        .ZONE_W    (ZONE_W)
    ) u_sel (
        .zone      (req_zone),
        .mode_flat (zone_mode),
        .set_flat  (zone_set),
        .mode      (sel_mode),
        .set       (sel_set)
    );

    zag_session #(
        .NUM_SETS  (NUM_SETS),
        .MAX_TRIES (MAX_TRIES),
        .SET_W     (SET_W),
        .TRY_W     (TRY_W)
    ) u_sess (
        .clk        (clk),
        .rst_n      (rst_n),
        .pw_valid   (pw_valid),
        .pw_set     (pw_set),
        .pw_write   (pw_write),
        .pw_ok      (pw_ok),
        .auth_ok    (auth_ok),
        .auth_fail  (auth_fail),
        .sess_valid (sess_valid),
        .sess_write (sess_write),
        .sess_set   (sess_set),
        .authed     (authed),
        .tries      (tries),
        .locked_out (locked_out)
    );

    assign set_match = sess_valid && (sess_set == sel_set);
    assign rd_ok     = !sel_mode.pw_en || set_match;
    assign wr_ok     = !sel_mode.pw_en || (set_match && sess_write);
    assign auth_cond = !sel_mode.auth_req || authed;
    assign access_ok = (req_write ? wr_ok : rd_ok) && auth_cond;

    zag_write_rules #(
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W)
    ) u_rules (
        .mode      (sel_mode),
        .is_write  (req_write),
        .first     (req_first),
        .access_ok (access_ok),
        .page_idx  (req_addr[PAGE_W-1:0]),
        .lock_byte (req_lock),
        .old_byte  (req_old),
        .new_byte  (req_wdata),
        .allow     (rule_allow),
        .data      (rule_data)
    );

    always_comb begin
        resp_d       = '0;
        resp_d.valid = req_valid;
        if (req_valid && rule_allow) begin
            resp_d.grant = 1'b1;
            resp_d.data  = rule_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign resp_valid = resp_q.valid;
    assign resp_grant = resp_q.grant;
    assign resp_deny  = resp_q.valid && !resp_q.grant;
    assign resp_data  = resp_q.data;

    p_resp_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    p_verdict_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $onehot({resp_grant, resp_deny}));
    p_denied_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_grant) |-> (resp_data == '0));
    p_nomod_denies_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && sel_mode.no_mod) |=> !resp_grant);
    p_prog_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && sel_mode.prog_only) |=> ((resp_data & ~$past(req_old)) == '0));
    p_trailing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && sel_mode.wlock && !req_first) |=> !resp_grant);
endmodule

// File: tb/zone_access_guard_bench.sv
module zone_access_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pw_valid = 1'b0, pw_write = 1'b0, pw_ok = 1'b0;
    logic [2:0]  pw_set = '0;
    logic        auth_ok = 1'b0, auth_fail = 1'b0;
    logic [79:0] zone_mode = '0;
    logic [47:0] zone_set = '0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_first = 1'b1;
    logic [3:0]  req_zone = '0;
    logic [8:0]  req_addr = '0;
    logic [7:0]  req_lock = '0, req_old = '0, req_wdata = '0;
    logic        resp_valid, resp_grant, resp_deny;
    logic [7:0]  resp_data;
    logic [2:0]  tries;
    logic        locked_out;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        logic       grant;
        logic [7:0] data;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    zone_access_guard u_zone_access_guard (
        .clk(clk), .rst_n(rst_n),
        .pw_valid(pw_valid), .pw_set(pw_set), .pw_write(pw_write), .pw_ok(pw_ok),
        .auth_ok(auth_ok), .auth_fail(auth_fail),
        .zone_mode(zone_mode), .zone_set(zone_set),
        .req_valid(req_valid), .req_write(req_write), .req_first(req_first),
        .req_zone(req_zone), .req_addr(req_addr), .req_lock(req_lock),
        .req_old(req_old), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_grant(resp_grant), .resp_deny(resp_deny),
        .resp_data(resp_data), .tries(tries), .locked_out(locked_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a verdict appears
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R11 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(resp_grant == e.grant && resp_deny == !e.grant,
                      {e.tag, " verdict"}, int'(resp_grant), int'(e.grant));
                check(resp_data == e.data, {e.tag, " data"}, int'(resp_data), int'(e.data));
            end
        end
    end

    task automatic access(input logic [3:0] z, input logic [8:0] a, input logic wr,
                          input logic first, input logic [7:0] lockb, input logic [7:0] old,
                          input logic [7:0] nw, input logic g, input logic [7:0] d,
                          input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_zone = z; req_addr = a; req_write = wr; req_first = first;
        req_lock = lockb; req_old = old; req_wdata = nw;
        e.grant = g; e.data = g ? d : 8'h00; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic present(input logic [2:0] s, input logic wr, input logic ok);
        @(negedge clk);
        pw_valid = 1'b1; pw_set = s; pw_write = wr; pw_ok = ok;
        @(negedge clk);
        pw_valid = 1'b0;
    endtask

    task automatic auth_pulse(input logic good);
        @(negedge clk);
        auth_ok = good; auth_fail = !good;
        @(negedge clk);
        auth_ok = 1'b0; auth_fail = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // mode bits: 4 pw_en, 3 auth_req, 2 wlock, 1 prog_only, 0 no_mod
        zone_mode[1*5 +: 5] = 5'b10000; zone_set[1*3 +: 3] = 3'd2;
        zone_mode[2*5 +: 5] = 5'b11000; zone_set[2*3 +: 3] = 3'd2;
        zone_mode[3*5 +: 5] = 5'b00001;
        zone_mode[4*5 +: 5] = 5'b00010;
        zone_mode[5*5 +: 5] = 5'b00100;
        zone_mode[6*5 +: 5] = 5'b00110;
        zone_mode[7*5 +: 5] = 5'b10000; zone_set[7*3 +: 3] = 3'd5;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(resp_valid == 1'b0, "R1 resp_valid", int'(resp_valid), 0);
        check(tries == 3'd0, "R1 tries", int'(tries), 0);
        check(locked_out == 1'b0, "R1 locked_out", int'(locked_out), 0);

        access(4'd0, 9'h010, 1'b0, 1'b1, 8'hFF, 8'h5A, 8'h00, 1'b1, 8'h5A, "R2 open read");
        access(4'd1, 9'h010, 1'b0, 1'b1, 8'hFF, 8'h11, 8'h00, 1'b0, 8'h00, "R2 no session read");
        access(4'd1, 9'h010, 1'b1, 1'b1, 8'hFF, 8'h11, 8'h22, 1'b0, 8'h00, "R3 no session write");

        present(3'd2, 1'b0, 1'b1);
        access(4'd1, 9'h020, 1'b0, 1'b1, 8'hFF, 8'h3C, 8'h00, 1'b1, 8'h3C, "R2 read pw read");
        access(4'd1, 9'h020, 1'b1, 1'b1, 8'hFF, 8'h3C, 8'h55, 1'b0, 8'h00, "R3 read pw write");
        access(4'd7, 9'h020, 1'b0, 1'b1, 8'hFF, 8'h3C, 8'h00, 1'b0, 8'h00, "R2 other set read");

        present(3'd2, 1'b1, 1'b1);
        access(4'd1, 9'h021, 1'b1, 1'b1, 8'hFF, 8'h00, 8'h77, 1'b1, 8'h77, "R3 write pw write");
        access(4'd1, 9'h021, 1'b0, 1'b1, 8'hFF, 8'h77, 8'h00, 1'b1, 8'h77, "R2 write pw read");

        access(4'd2, 9'h000, 1'b0, 1'b1, 8'hFF, 8'h99, 8'h00, 1'b0, 8'h00, "R6 no auth read");
        auth_pulse(1'b1);
        access(4'd2, 9'h000, 1'b0, 1'b1, 8'hFF, 8'h99, 8'h00, 1'b1, 8'h99, "R6 auth read");
        access(4'd2, 9'h001, 1'b1, 1'b1, 8'hFF, 8'h00, 8'hA5, 1'b1, 8'hA5, "R6 auth write");
        auth_pulse(1'b0);
        access(4'd2, 9'h000, 1'b0, 1'b1, 8'hFF, 8'h99, 8'h00, 1'b0, 8'h00, "R6 auth dropped");

        access(4'd3, 9'h004, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'h00, 1'b0, 8'h00, "R7 forbidden write");
        access(4'd3, 9'h004, 1'b0, 1'b1, 8'hFF, 8'hC3, 8'h00, 1'b1, 8'hC3, "R7 forbidden read");

        access(4'd4, 9'h100, 1'b1, 1'b1, 8'hFF, 8'hF0, 8'h3C, 1'b1, 8'h30, "R8 clear only");

        access(4'd5, 9'h00B, 1'b1, 1'b1, 8'hF7, 8'h00, 8'hAB, 1'b0, 8'h00, "R9 locked byte");
        access(4'd5, 9'h00A, 1'b1, 1'b1, 8'hF7, 8'h00, 8'hAB, 1'b1, 8'hAB, "R9 open byte");
        access(4'd5, 9'h008, 1'b1, 1'b1, 8'hF7, 8'hF7, 8'h0F, 1'b1, 8'h07, "R9 lock byte clear");
        access(4'd5, 9'h008, 1'b1, 1'b1, 8'hF6, 8'hF6, 8'hFE, 1'b0, 8'h00, "R9 lock byte frozen");
        access(4'd6, 9'h011, 1'b1, 1'b1, 8'hFF, 8'h0F, 8'hF5, 1'b1, 8'h05, "R9 lock with R8");
        access(4'd5, 9'h00A, 1'b1, 1'b0, 8'hFF, 8'h00, 8'h12, 1'b0, 8'h00, "R10 trailing byte");
        access(4'd5, 9'h00A, 1'b1, 1'b1, 8'hFF, 8'h00, 8'h12, 1'b1, 8'h12, "R10 first byte");

        present(3'd5, 1'b0, 1'b1);
        access(4'd1, 9'h021, 1'b0, 1'b1, 8'hFF, 8'h77, 8'h00, 1'b0, 8'h00, "R4 replaced session");
        access(4'd7, 9'h021, 1'b0, 1'b1, 8'hFF, 8'h44, 8'h00, 1'b1, 8'h44, "R4 new session");
        present(3'd5, 1'b0, 1'b0);
        check(tries == 3'd1, "R5 one wrong", int'(tries), 1);
        access(4'd7, 9'h021, 1'b0, 1'b1, 8'hFF, 8'h44, 8'h00, 1'b0, 8'h00, "R4 wrong drops");
        present(3'd5, 1'b0, 1'b1);
        check(tries == 3'd0, "R5 correct resets", int'(tries), 0);
        for (int k = 0; k < 5; k++) present(3'd5, 1'b0, 1'b0);
        check(tries == 3'd4, "R5 saturate", int'(tries), 4);
        check(locked_out == 1'b1, "R5 locked_out", int'(locked_out), 1);
        present(3'd5, 1'b0, 1'b1);
        check(tries == 3'd4, "R5 ignored correct", int'(tries), 4);
        access(4'd7, 9'h021, 1'b0, 1'b1, 8'hFF, 8'h44, 8'h00, 1'b0, 8'h00, "R5 no session at limit");

        do_reset();
        @(negedge clk);
        check(tries == 3'd0, "R1 reset tries", int'(tries), 0);
        check(locked_out == 1'b0, "R1 reset locked_out", int'(locked_out), 0);
        access(4'd1, 9'h021, 1'b0, 1'b1, 8'hFF, 8'h77, 8'h00, 1'b0, 8'h00, "R1 session cleared");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R11 missing responses", sb.size(), 0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule